// File: doc/BRIEF.md
# GCI Two-Slot B-Channel Port

This block is the B-channel end of a GCI-style time-division serial link. Each 8 kHz frame carries two bytes back to back, and every bit of a byte lasts two cycles of the data clock. The first byte slot takes frame cycles 0 to 15 and the second takes cycles 16 to 31. A channel-select input picks which of the two slots this port transmits into and receives from. Outgoing data changes on rising data-clock edges. Incoming data is sampled on the falling edge in the second half of each bit.

The port turns on only after a second bit-clock pin has stayed low for two or more whole frames. It turns off as soon as that pin shows any activity again. While it is on, the port drives its serial output and output-enable during its own slot, shifts in the peer's byte from the same slot, and gives the received byte together with a single-cycle valid strobe.

Top module: `gci_bslot_port`

## Requirements
- R1: While reset is asserted and after it is released, dout_oe_o, dout_o, rx_valid_o and rx_byte_o are all 0 until a frame has run in the active mode.
- R2: The port becomes active only at the (QUAL_FRAMES+1)-th frame start after alt_bclk_i was last sampled high. That frame and the frames after it carry traffic. Every earlier frame keeps dout_oe_o low.
- R3: If alt_bclk_i is sampled high at a rising edge, the port is inactive from that same edge: dout_oe_o is low from that edge on, and the slot in progress produces no rx_valid_o.
- R4: The rising edge at which fsync_i is first sampled high after being low is frame cycle 0. The cycle count restarts at every such edge, even in the middle of a slot.
- R5: chan_sel_i is sampled at the cycle-0 edge. A value of 0 selects slot cycles 0..15 and a value of 1 selects cycles 16..31, for both transmit and receive. Later changes within the frame have no effect.
- R6: In an active frame, dout_oe_o is high in exactly the 16 cycles of the selected slot. dout_o is 0 whenever dout_oe_o is low.
- R7: tx_byte_i is sampled at the cycle-0 edge and sent MSB first. Slot cycles 2k and 2k+1 carry bit 7-k, and the value changes only on rising edges.
- R8: din_i is sampled on the falling edge inside slot cycle 2k+1 and becomes bit 7-k of the received byte.
- R9: rx_valid_o is a one-cycle pulse in frame cycle base+16, with rx_byte_o holding the byte just received. rx_byte_o keeps that value until the next pulse.
- R10: The cycle count saturates at its maximum, so a frame longer than the count range never re-enters a slot before the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dcl_i | input | 1 | Data clock, two cycles per bit |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | Frame sync; its rising edge starts frame cycle 0 |
| chan_sel_i | input | 1 | Slot select: 0 = first byte slot, 1 = second |
| alt_bclk_i | input | 1 | Second bit-clock pin watched for mode entry (must stay low) |
| din_i | input | 1 | Serial receive data |
| tx_byte_i | input | BYTE_W | Byte sent in the selected slot |
| dout_o | output | 1 | Serial transmit data |
| dout_oe_o | output | 1 | Output enable for dout_o |
| rx_byte_o | output | BYTE_W | Last byte received from the selected slot |
| rx_valid_o | output | 1 | One-cycle strobe when rx_byte_o is updated |

## Verification
The bench builds the port with BYTE_W = 8, QUAL_FRAMES = 2 and CNT_W = 6, so the cycle count saturates at 63. A single 100-cycle frame then drives the counter into saturation, and any wrap back into the first slot shows up on the output enable. With a two-frame qualification window, the bench can reach mode entry, mid-slot exit and re-entry within a few short frames, and can check the exact frame where traffic starts. Frame lengths between 34 and 63 cycles, random frame-sync widths and a truncated 20-cycle frame check the restart rule on both slots.

// File: rtl/gci_pkg.sv
package gci_pkg;

    // Each serial bit spans 2**BIT_SHIFT data-clock cycles.
    localparam int unsigned BIT_SHIFT    = 1;
    localparam int unsigned CLKS_PER_BIT = 1 << BIT_SHIFT;

    typedef enum logic {
        SLOT_FIRST  = 1'b0,
        SLOT_SECOND = 1'b1
    } slot_e;

endpackage

// File: rtl/gci_mode_qual.sv
module gci_mode_qual #(
    parameter int unsigned QUAL_FRAMES = 2
) (
    input  logic dcl_i,
    input  logic rst_ni,
    input  logic alt_i,
    input  logic fs_rise_i,
    output logic active_d_o,
    output logic active_q_o
);

    localparam int unsigned         QW   = $clog2(QUAL_FRAMES + 2);
    localparam logic [QW-1:0]       QMAX = QW'(QUAL_FRAMES + 1);

    typedef struct packed {
        logic [QW-1:0] quiet;
        logic          active;
    } qual_t;

    qual_t q_d, q_q;

    // Count frame starts seen since the pin last showed a high sample.
    always_comb begin
        q_d = q_q;
        if (alt_i) begin
            q_d.quiet = '0;
        end else if (fs_rise_i && (q_q.quiet != QMAX)) begin
            q_d.quiet = q_q.quiet + 1'b1;
        end
        q_d.active = !alt_i && (q_d.quiet == QMAX);
    end

    always_ff @(posedge dcl_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q_q <= '{quiet: '0, active: 1'b0};
        end else begin
            q_q <= q_d;
        end
    end

    assign active_d_o = q_d.active;
    assign active_q_o = q_q.active;

    AST_ENTRY_AT_FRAME: assert property (@(posedge dcl_i) disable iff (!rst_ni)
        $rose(q_q.active) |-> $past(fs_rise_i)); // R2

endmodule

// File: rtl/gci_slot_timer.sv
module gci_slot_timer #(
    parameter int unsigned CNT_W = 9
) (
    input  logic                 dcl_i,
    input  logic                 rst_ni,
    input  logic                 fsync_i,
    input  logic                 sel_i,
    output logic                 fs_rise_o,
    output logic [CNT_W-1:0]     cnt_d_o,
    output logic [CNT_W-1:0]     cnt_q_o,
    output gci_pkg::slot_e       sel_d_o,
    output gci_pkg::slot_e       sel_q_o
);

    import gci_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             fs;
        logic [CNT_W-1:0] cnt;
        slot_e            sel;
    } tmr_t;

    tmr_t t_d, t_q;
    logic fs_rise;

    always_comb begin
        t_d     = t_q;
        fs_rise = fsync_i && !t_q.fs;
        t_d.fs  = fsync_i;
        if (fs_rise) begin
            t_d.cnt = '0;
            t_d.sel = slot_e'(sel_i);
        end else if (t_q.cnt != CNT_MAX) begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge dcl_i or negedge rst_ni) begin
        if (!rst_ni) begin
            t_q <= '{fs: 1'b0, cnt: CNT_MAX, sel: SLOT_FIRST};
        end else begin
            t_q <= t_d;
        end
    end

    assign fs_rise_o = fs_rise;
    assign cnt_d_o   = t_d.cnt;
    assign cnt_q_o   = t_q.cnt;
    assign sel_d_o   = t_d.sel;
    assign sel_q_o   = t_q.sel;

    AST_CNT_RESTART: assert property (@(posedge dcl_i) disable iff (!rst_ni)
        fs_rise |=> (t_q.cnt == '0)); // R4

    AST_CNT_SATURATE: assert property (@(posedge dcl_i) disable iff (!rst_ni)
        (!fs_rise && (t_q.cnt == CNT_MAX)) |=> (t_q.cnt == CNT_MAX)); // R10

endmodule

// File: rtl/gci_tx.sv
module gci_tx #(
    parameter int unsigned BYTE_W   = 8,
    parameter int unsigned CNT_W    = 9,
    parameter int unsigned SLOT_LEN = 16
) (
    input  logic               dcl_i,
    input  logic               rst_ni,
    input  logic               fs_rise_i,
    input  logic [CNT_W-1:0]   cnt_d_i,
    input  gci_pkg::slot_e     sel_d_i,
    input  logic               active_d_i,
    input  logic [BYTE_W-1:0]  tx_byte_i,
    output logic               dout_o,
    output logic               oe_o
);

    import gci_pkg::*;

    localparam int unsigned      IW     = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CNT_W-1:0] SLOT_C = CNT_W'(SLOT_LEN);
    localparam logic [IW-1:0]    TOP_C  = IW'(BYTE_W - 1);

    typedef struct packed {
        logic [BYTE_W-1:0] hold;
        logic              dout;
        logic              oe;
    } tx_t;

    tx_t x_d, x_q;

    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] off;
    logic             in_slot;
    logic [IW-1:0]    pos;

    always_comb begin
        x_d     = x_q;
        base    = (sel_d_i == SLOT_SECOND) ? SLOT_C : '0;
        off     = cnt_d_i - base;
        in_slot = (cnt_d_i >= base) && (off < SLOT_C);
        pos     = TOP_C - IW'(off >> BIT_SHIFT);
        if (fs_rise_i) begin
            x_d.hold = tx_byte_i;
        end
        x_d.oe   = active_d_i && in_slot;
        x_d.dout = x_d.oe ? x_d.hold[pos] : 1'b0;
    end

    always_ff @(posedge dcl_i or negedge rst_ni) begin
        if (!rst_ni) begin
            x_q <= '{hold: '0, dout: 1'b0, oe: 1'b0};
        end else begin
            x_q <= x_d;
        end
    end

    assign dout_o = x_q.dout;
    assign oe_o   = x_q.oe;

    AST_OE_STARTS_AT_BASE: assert property (@(posedge dcl_i) disable iff (!rst_ni)
        $rose(x_q.oe) |-> ($past(cnt_d_i) == $past(base))); // R6

endmodule

// File: rtl/gci_rx.sv
module gci_rx #(
    parameter int unsigned BYTE_W   = 8,
    parameter int unsigned CNT_W    = 9,
    parameter int unsigned SLOT_LEN = 16
) (
    input  logic               dcl_i,
    input  logic               rst_ni,
    input  logic               din_i,
    input  logic [CNT_W-1:0]   cnt_q_i,
    input  gci_pkg::slot_e     sel_q_i,
    input  logic               active_q_i,
    input  logic               active_d_i,
    output logic [BYTE_W-1:0]  rx_byte_o,
    output logic               rx_valid_o
);

    import gci_pkg::*;

    localparam logic [CNT_W-1:0] SLOT_C = CNT_W'(SLOT_LEN);

    typedef struct packed {
        logic [BYTE_W-1:0] sh;
    } cap_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              valid;
    } out_t;

    cap_t c_d, c_q;
    out_t o_d, o_q;

    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] off;
    logic             in_slot;
    logic             take;
    logic             done;

    // Falling-edge capture in the second half of each bit period.
    always_comb begin
        c_d     = c_q;
        base    = (sel_q_i == SLOT_SECOND) ? SLOT_C : '0;
        off     = cnt_q_i - base;
        in_slot = (cnt_q_i >= base) && (off < SLOT_C);
        take    = active_q_i && in_slot && (&off[BIT_SHIFT-1:0]);
        if (take) begin
            c_d.sh = {c_q.sh[BYTE_W-2:0], din_i};
        end
    end

    always_ff @(negedge dcl_i or negedge rst_ni) begin
        if (!rst_ni) begin
            c_q <= '{sh: '0};
        end else begin
            c_q <= c_d;
        end
    end

    // Hand the byte over at the rising edge that ends the slot.
    always_comb begin
        o_d       = o_q;
        done      = active_q_i && active_d_i && (cnt_q_i == (base + SLOT_C - 1'b1));
        o_d.valid = done;
        if (done) begin
            o_d.data = c_q.sh;
        end
    end

    always_ff @(posedge dcl_i or negedge rst_ni) begin
        if (!rst_ni) begin
            o_q <= '{data: '0, valid: 1'b0};
        end else begin
            o_q <= o_d;
        end
    end

    assign rx_byte_o  = o_q.data;
    assign rx_valid_o = o_q.valid;

    AST_VALID_SINGLE: assert property (@(posedge dcl_i) disable iff (!rst_ni)
        o_q.valid |=> !o_q.valid); // R9

    AST_BYTE_HELD: assert property (@(posedge dcl_i) disable iff (!rst_ni)
        !o_q.valid |-> $stable(o_q.data)); // R9

endmodule

// File: rtl/gci_bslot_port.sv
module gci_bslot_port #(
    parameter int unsigned BYTE_W      = 8,
    parameter int unsigned CNT_W       = 9,
    parameter int unsigned QUAL_FRAMES = 2
) (
    input  logic              dcl_i,
    input  logic              rst_ni,
    input  logic              fsync_i,
    input  logic              chan_sel_i,
    input  logic              alt_bclk_i,
    input  logic              din_i,
    input  logic [BYTE_W-1:0] tx_byte_i,
    output logic              dout_o,
    output logic              dout_oe_o,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic              rx_valid_o
);

    import gci_pkg::*;

    localparam int unsigned      SLOT_LEN = CLKS_PER_BIT * BYTE_W;
    localparam logic [CNT_W-1:0] SLOT_C   = CNT_W'(SLOT_LEN);

    logic             fs_rise;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_q;
    slot_e            sel_d;
    slot_e            sel_q;
    logic             active_d;
    logic             active_q;

    gci_slot_timer #(
        .CNT_W (CNT_W)
    ) i_timer (
        .dcl_i     (dcl_i),
        .rst_ni    (rst_ni),
        .fsync_i   (fsync_i),
        .sel_i     (chan_sel_i),
        .fs_rise_o (fs_rise),
        .cnt_d_o   (cnt_d),
        .cnt_q_o   (cnt_q),
        .sel_d_o   (sel_d),
        .sel_q_o   (sel_q)
    );

    gci_mode_qual #(
        .QUAL_FRAMES (QUAL_FRAMES)
    ) i_qual (
        .dcl_i      (dcl_i),
        .rst_ni     (rst_ni),
        .alt_i      (alt_bclk_i),
        .fs_rise_i  (fs_rise),
        .active_d_o (active_d),
        .active_q_o (active_q)
    );

    gci_tx #(
        .BYTE_W   (BYTE_W),
        .CNT_W    (CNT_W),
        .SLOT_LEN (SLOT_LEN)
    ) i_tx (
        .dcl_i      (dcl_i),
        .rst_ni     (rst_ni),
        .fs_rise_i  (fs_rise),
        .cnt_d_i    (cnt_d),
        .sel_d_i    (sel_d),
        .active_d_i (active_d),
        .tx_byte_i  (tx_byte_i),
        .dout_o     (dout_o),
        .oe_o       (dout_oe_o)
    );

    gci_rx #(
        .BYTE_W   (BYTE_W),
        .CNT_W    (CNT_W),
        .SLOT_LEN (SLOT_LEN)
    ) i_rx (
        .dcl_i      (dcl_i),
        .rst_ni     (rst_ni),
        .din_i      (din_i),
        .cnt_q_i    (cnt_q),
        .sel_q_i    (sel_q),
        .active_q_i (active_q),
        .active_d_i (active_d),
        .rx_byte_o  (rx_byte_o),
        .rx_valid_o (rx_valid_o)
    );

    logic [CNT_W-1:0] cur_base;
    assign cur_base = (sel_q == SLOT_SECOND) ? SLOT_C : '0;

    AST_OE_NEEDS_MODE: assert property (@(posedge dcl_i) disable iff (!rst_ni)
        dout_oe_o |-> active_q); // R6

    AST_OE_IN_SLOT: assert property (@(posedge dcl_i) disable iff (!rst_ni)
        dout_oe_o |-> ((cnt_q >= cur_base) && ((cnt_q - cur_base) < SLOT_C))); // R5

    AST_EXIT_QUIET: assert property (@(posedge dcl_i) disable iff (!rst_ni)
        alt_bclk_i |=> (!dout_oe_o && !rx_valid_o)); // R3

    AST_BIT_HELD: assert property (@(posedge dcl_i) disable iff (!rst_ni)
        (dout_oe_o && cnt_q[0]) |-> $stable(dout_o)); // R7

endmodule

// File: tb/test_gci_bslot_port.sv
module test_gci_bslot_port;

    localparam int CLK_PERIOD  = 10;
    localparam int BYTE_W      = 8;
    localparam int CNT_W       = 6;
    localparam int QUAL_FRAMES = 2;
    localparam int QMAX        = QUAL_FRAMES + 1;

    logic       dcl = 1'b0;
    logic       rst_n;
    logic       fsync, chan_sel, alt_bclk, din;
    logic [7:0] tx_byte;
    logic       dout, dout_oe, rx_valid;
    logic [7:0] rx_byte;

    int n_chk  = 0;
    int n_fail = 0;
    int quiet  = 0;
    logic [7:0] last_rx = 8'h00;

    always #(CLK_PERIOD/2) dcl = ~dcl;

    gci_bslot_port #(
        .BYTE_W      (BYTE_W),
        .CNT_W       (CNT_W),
        .QUAL_FRAMES (QUAL_FRAMES)
    ) i_gci_bslot_port (
        .dcl_i      (dcl),
        .rst_ni     (rst_n),
        .fsync_i    (fsync),
        .chan_sel_i (chan_sel),
        .alt_bclk_i (alt_bclk),
        .din_i      (din),
        .tx_byte_i  (tx_byte),
        .dout_o     (dout),
        .dout_oe_o  (dout_oe),
        .rx_byte_o  (rx_byte),
        .rx_valid_o (rx_valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit exp_tx_bit(input logic [7:0] b, input int off);
        return b[7 - off/2];
    endfunction

    function automatic bit in_slot(input int c, input int base);
        return (c >= base) && (c < base + 16);
    endfunction

    // alt_mode: 0 low, 1 toggling, 2 one high sample at edge alt_at+1
    task automatic run_frame(input int len, input int fsw, input bit sel,
                             input logic [7:0] tx, input logic [7:0] rx,
                             input int alt_mode, input int alt_at, input string tag);
        int  base;
        bit  act;
        bit  alive;
        bit  a;
        base  = sel ? 16 : 0;
        alive = 1'b0;
        for (int c = 0; c < len; c++) begin
            fsync = (c < fsw);
            case (alt_mode)
                1:       a = c[0];
                2:       a = (c == alt_at + 1);
                default: a = 1'b0;
            endcase
            alt_bclk = a;
            if (c == 0) begin
                chan_sel = sel;
                tx_byte  = tx;
            end
            @(posedge dcl);
            #2;
            // the edge just taken sampled the values driven above
            if (a) quiet = 0;
            else if (c == 0 && quiet < QMAX) quiet++;
            act   = !a && (quiet == QMAX);
            alive = (c == 0) ? act : (alive && act);
            // scramble latched inputs inside the frame
            chan_sel = 1'($urandom);
            tx_byte  = 8'($urandom);
            check(tag, dout_oe, act && in_slot(c, base));
            check("R7", dout, (act && in_slot(c, base)) ? exp_tx_bit(tx, c - base) : 1'b0);
            check("R9", rx_valid, alive && (c == base + 16));
            if (alive && c == base + 16) begin
                last_rx = rx;
                check("R8", rx_byte, rx);
            end
            if (in_slot(c, base) && ((c - base) % 2 == 1))
                din = rx[7 - (c - base)/2];
            else
                din = 1'($urandom);
        end
        check("R9", rx_byte, last_rx);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd7351));
        rst_n = 1'b0; fsync = 1'b0; chan_sel = 1'b0; alt_bclk = 1'b0;
        din = 1'b0; tx_byte = 8'h00;
        repeat (3) @(posedge dcl);
        #2;
        check("R1", {dout_oe, dout, rx_valid}, 3'b000);
        check("R1", rx_byte, 8'h00);
        rst_n = 1'b1;
        repeat (2) @(posedge dcl);
        #2;
        check("R1", {dout_oe, dout, rx_valid}, 3'b000);
        check("R1", rx_byte, 8'h00);

        // R2: toggling pin blocks entry, then exactly QUAL_FRAMES+1 starts
        run_frame(40, 2, 1'b0, 8'hA5, 8'h3C, 1, 0, "R2");
        run_frame(40, 1, 1'b1, 8'h5A, 8'hC3, 1, 0, "R2");
        run_frame(40, 2, 1'b0, 8'hFF, 8'h11, 0, 0, "R2");
        run_frame(40, 2, 1'b0, 8'hFF, 8'h22, 0, 0, "R2");
        run_frame(40, 2, 1'b0, 8'hC5, 8'h96, 0, 0, "R2");

        // R5: directed slot choice, edge patterns
        run_frame(44, 3, 1'b1, 8'h80, 8'h01, 0, 0, "R5");
        run_frame(44, 1, 1'b0, 8'h01, 8'h80, 0, 0, "R5");
        run_frame(36, 4, 1'b1, 8'h00, 8'hFF, 0, 0, "R5");

        // R6: random traffic
        for (int i = 0; i < 30; i++) begin
            run_frame(34 + int'($urandom % 30), 1 + int'($urandom % 4), 1'($urandom),
                      8'($urandom), 8'($urandom), 0, 0, "R6");
        end

        // R3: pin activity inside the slot, then re-qualification
        run_frame(48, 2, 1'b0, 8'hE7, 8'h5B, 2, 6, "R3");
        run_frame(48, 2, 1'b1, 8'h42, 8'h24, 0, 0, "R3");
        run_frame(48, 2, 1'b1, 8'h42, 8'h24, 0, 0, "R3");
        run_frame(48, 2, 1'b1, 8'h99, 8'h66, 0, 0, "R2");
        run_frame(48, 2, 1'b1, 8'h17, 8'hD4, 2, 20, "R3");
        run_frame(40, 2, 1'b0, 8'h00, 8'h00, 0, 0, "R3");
        run_frame(40, 2, 1'b0, 8'h00, 8'h00, 0, 0, "R3");
        run_frame(40, 2, 1'b0, 8'hB2, 8'h4D, 0, 0, "R2");

        // R4: frame cut short in the middle of the second slot
        run_frame(20, 2, 1'b1, 8'hF0, 8'h0F, 0, 0, "R4");
        run_frame(40, 2, 1'b1, 8'h3A, 8'hA3, 0, 0, "R4");

        // R10: frame longer than the count range
        run_frame(100, 2, 1'b0, 8'h6E, 8'hE6, 0, 0, "R10");
        run_frame(100, 2, 1'b1, 8'h81, 8'h18, 0, 0, "R10");
        run_frame(40, 2, 1'b0, 8'h55, 8'hAA, 0, 0, "R10");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule